// File: doc/BRIEF.md
# Unified Data-Space Address Decoder with Core Control Registers

This block sits between an 8-bit core's byte load/store path and the three places a data address can land. The lowest 32 addresses reach the general-purpose register file, the next 64 addresses form the I/O window, and every address above that goes to data memory. The decoder turns one access request into a strobe and an index for exactly one of these targets. It also returns the read data from whichever target the address selects.

The top eight ports of the I/O window are not forwarded. They hold registers that the core owns and that this block stores itself:
- four page registers, each an 8-bit value that supplies bits 23:16 of an extended data address;
- an extension byte for indirect jumps;
- the low and high bytes of the stack pointer;
- the status byte.

Writes to the page registers and to the stack pointer's high byte depend on feature parameters. When a feature is off, the write is dropped. All other I/O ports are passed to an external I/O bus with the same port number.

Top module: `dspace_decode`

## Requirements
- R1: An address below 32 selects the general registers: `gpr_re`/`gpr_we` follow `acc_rd`/`acc_wr`, `gpr_idx` equals the address, and `acc_rdata` returns `gpr_rdata`.
- R2: An address from 32 to 87 is forwarded to the I/O bus. `io_port` equals address − 32, `io_re`/`io_we` follow the request, `out_wdata` carries the write byte, and `acc_rdata` returns `io_rdata`.
- R3: An address of 96 or above selects memory. `mem_addr` equals the address, `mem_re`/`mem_we` follow the request, and `acc_rdata` returns `mem_rdata`.
- R4: At most one target strobe is active in any cycle. With neither `acc_rd` nor `acc_wr` asserted, no strobe is active.
- R5: Ports 56, 57, 58 and 59 (addresses 88 to 91) are the D, X, Y and Z page registers. When a page register's enable bit in `PAGE_EN` is set (bit 0 = D … bit 3 = Z), a write stores the byte. The byte then appears on that register's output and in reads.
- R6: With a page register's enable bit clear, a write to it is dropped. Its output stays zero and a read of it returns zero.
- R7: Port 60 (address 92) is the jump-extension byte and is always writable.
- R8: A write to port 61 (address 93) replaces `stack_ptr[7:0]` and leaves bits 15:8 unchanged. A write to port 62 (address 94) replaces `stack_ptr[15:8]` when `SP_WIDE` is 1. Reads of these ports return the matching byte.
- R9: With `SP_WIDE` = 0, writes to port 62 are dropped and `stack_ptr[15:8]` reads back as zero.
- R10: Port 63 (address 95) is the status byte and can be read and written.
- R11: An access to ports 56 to 63 never asserts `io_re` or `io_we`.
- R12: After reset, all core registers are zero.
- R13: Reads are combinational from the address. A write changes a core register only at the rising clock edge where `acc_wr` is high, and core registers stay unchanged in cycles without a core write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_addr | input | ADDR_W | Data-space byte address |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte from the selected target |
| gpr_idx | output | GPR_W | General register index |
| gpr_re | output | 1 | General register read strobe |
| gpr_we | output | 1 | General register write strobe |
| gpr_rdata | input | 8 | General register read byte |
| io_port | output | IO_W | External I/O port number |
| io_re | output | 1 | External I/O read strobe |
| io_we | output | 1 | External I/O write strobe |
| io_rdata | input | 8 | External I/O read byte |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read byte |
| out_wdata | output | 8 | Write byte sent to all external targets |
| page_d | output | 8 | D page byte (extended address bits 23:16) |
| page_x | output | 8 | X page byte |
| page_y | output | 8 | Y page byte |
| page_z | output | 8 | Z page byte |
| jmp_ext | output | 8 | Jump-extension byte |
| stack_ptr | output | 16 | Stack pointer |
| status | output | 8 | Status byte |

## Verification
Some properties are checked by assertions on every cycle:
- strobe exclusivity;
- the silence of the I/O bus during core-register accesses;
- the port arithmetic of forwarded accesses;
- write-through of enabled page, jump-extension and stack bytes;
- the stability of core registers in cycles without a core write.

Other behaviours can only be shown by the bench's scenarios:
- the region boundaries at 31/32, 87/88 and 95/96;
- the dropped writes to disabled page registers;
- the narrow stack-pointer configuration;
- the read data returned for each target.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  typedef enum logic [1:0] {
    RG_GPR  = 2'd0,
    RG_IO   = 2'd1,
    RG_CORE = 2'd2,
    RG_MEM  = 2'd3
  } region_e;

  // Offset of each core register within the top block of eight I/O ports.
  localparam logic [2:0] CR_PAGE_D = 3'd0;
  localparam logic [2:0] CR_PAGE_X = 3'd1;
  localparam logic [2:0] CR_PAGE_Y = 3'd2;
  localparam logic [2:0] CR_PAGE_Z = 3'd3;
  localparam logic [2:0] CR_JEXT   = 3'd4;
  localparam logic [2:0] CR_SP_LO  = 3'd5;
  localparam logic [2:0] CR_SP_HI  = 3'd6;
  localparam logic [2:0] CR_STATUS = 3'd7;

  localparam int unsigned CORE_REGS = 8;

  // Classify a widened data address into its target region.
  function automatic region_e region_of(input logic [31:0] a,
                                        input int unsigned gprs,
                                        input int unsigned ios);
    if (a < gprs)
      return RG_GPR;
    else if (a < gprs + ios - CORE_REGS)
      return RG_IO;
    else if (a < gprs + ios)
      return RG_CORE;
    else
      return RG_MEM;
  endfunction

  // I/O port number of a data address inside the I/O window.
  function automatic logic [31:0] port_of(input logic [31:0] a,
                                          input int unsigned gprs);
    return a - gprs;
  endfunction

endpackage

// File: rtl/dsd_region_decode.sv
module dsd_region_decode
  import dsd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned GPR_N  = 32,
  parameter int unsigned IO_N   = 64,
  localparam int unsigned GPR_W = $clog2(GPR_N),
  localparam int unsigned IO_W  = $clog2(IO_N)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [GPR_W-1:0]  gpr_idx,
  output logic [IO_W-1:0]   io_port,
  output logic [2:0]        core_sel
);

  logic [31:0] a32;
  logic [31:0] port32;

  assign a32    = 32'(addr);
  assign port32 = port_of(a32, GPR_N);

  always_comb begin
    region   = region_of(a32, GPR_N, IO_N);
    gpr_idx  = a32[GPR_W-1:0];
    io_port  = port32[IO_W-1:0];
    core_sel = port32[2:0];
  end

endmodule

// File: rtl/dsd_core_regs.sv
module dsd_core_regs
  import dsd_pkg::*;
#(
  parameter logic [3:0] PAGE_EN = 4'b1110,
  parameter bit         SP_WIDE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [2:0]  sel,
  input  logic [7:0]  wdata,
  output logic [7:0]  page_q [4],
  output logic [7:0]  jext_q,
  output logic [15:0] sp_q,
  output logic [7:0]  sreg_q,
  output logic [7:0]  rd_val
);

  logic [7:0] sp_lo_q;
  logic [7:0] sp_hi_q;

  for (genvar g = 0; g < 4; g++) begin : g_page
    if (PAGE_EN[g]) begin : g_on
      logic [7:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          val_q <= 8'h00;
        else if (we && sel == 3'(g))
          val_q <= wdata;
      end
      assign page_q[g] = val_q;

      // R5
      page_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == 3'(g)) |=> (page_q[g] == $past(wdata)));
    end else begin : g_off
      assign page_q[g] = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jext_q  <= 8'h00;
      sp_lo_q <= 8'h00;
      sreg_q  <= 8'h00;
    end else if (we) begin
      case (sel)
        CR_JEXT:   jext_q  <= wdata;
        CR_SP_LO:  sp_lo_q <= wdata;
        CR_STATUS: sreg_q  <= wdata;
        default: ;
      endcase
    end
  end

  if (SP_WIDE) begin : g_sp_wide
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sp_hi_q <= 8'h00;
      else if (we && sel == CR_SP_HI)
        sp_hi_q <= wdata;
    end
  end else begin : g_sp_narrow
    assign sp_hi_q = 8'h00;
  end

  assign sp_q = {sp_hi_q, sp_lo_q};

  always_comb begin
    case (sel)
      CR_PAGE_D: rd_val = page_q[0];
      CR_PAGE_X: rd_val = page_q[1];
      CR_PAGE_Y: rd_val = page_q[2];
      CR_PAGE_Z: rd_val = page_q[3];
      CR_JEXT:   rd_val = jext_q;
      CR_SP_LO:  rd_val = sp_q[7:0];
      CR_SP_HI:  rd_val = sp_q[15:8];
      default:   rd_val = sreg_q;
    endcase
  end

  // R7
  jext_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == CR_JEXT) |=> (jext_q == $past(wdata)));

  // R8
  sp_lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == CR_SP_LO) |=>
      (sp_q[7:0] == $past(wdata) && sp_q[15:8] == $past(sp_q[15:8])));

  // R13
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(sp_q) && $stable(sreg_q) && $stable(jext_q)));

endmodule

// File: rtl/dsd_read_mux.sv
module dsd_read_mux
  import dsd_pkg::*;
(
  input  region_e    region,
  input  logic [7:0] gpr_rdata,
  input  logic [7:0] io_rdata,
  input  logic [7:0] core_rdata,
  input  logic [7:0] mem_rdata,
  output logic [7:0] rdata
);

  always_comb begin
    unique case (region)
      RG_GPR:  rdata = gpr_rdata;
      RG_IO:   rdata = io_rdata;
      RG_CORE: rdata = core_rdata;
      default: rdata = mem_rdata;
    endcase
  end

endmodule

// File: rtl/dspace_decode.sv
module dspace_decode
  import dsd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned GPR_N   = 32,
  parameter int unsigned IO_N    = 64,
  parameter logic [3:0]  PAGE_EN = 4'b1110,
  parameter bit          SP_WIDE = 1'b1,
  localparam int unsigned GPR_W  = $clog2(GPR_N),
  localparam int unsigned IO_W   = $clog2(IO_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  output logic [GPR_W-1:0]  gpr_idx,
  output logic              gpr_re,
  output logic              gpr_we,
  input  logic [7:0]        gpr_rdata,
  output logic [IO_W-1:0]   io_port,
  output logic              io_re,
  output logic              io_we,
  input  logic [7:0]        io_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        out_wdata,
  output logic [7:0]        page_d,
  output logic [7:0]        page_x,
  output logic [7:0]        page_y,
  output logic [7:0]        page_z,
  output logic [7:0]        jmp_ext,
  output logic [15:0]       stack_ptr,
  output logic [7:0]        status
);

  region_e    region;
  logic [2:0] core_sel;
  logic       core_we;
  logic [7:0] core_rdata;
  logic [7:0] page_q [4];

  dsd_region_decode #(
    .ADDR_W(ADDR_W), .GPR_N(GPR_N), .IO_N(IO_N)
  ) u_dec (
    .addr     (acc_addr),
    .region   (region),
    .gpr_idx  (gpr_idx),
    .io_port  (io_port),
    .core_sel (core_sel)
  );

  assign gpr_re  = acc_rd && region == RG_GPR;
  assign gpr_we  = acc_wr && region == RG_GPR;
  assign io_re   = acc_rd && region == RG_IO;
  assign io_we   = acc_wr && region == RG_IO;
  assign mem_re  = acc_rd && region == RG_MEM;
  assign mem_we  = acc_wr && region == RG_MEM;
  assign core_we = acc_wr && region == RG_CORE;

  assign mem_addr  = acc_addr;
  assign out_wdata = acc_wdata;

  dsd_core_regs #(
    .PAGE_EN(PAGE_EN), .SP_WIDE(SP_WIDE)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (core_we),
    .sel    (core_sel),
    .wdata  (acc_wdata),
    .page_q (page_q),
    .jext_q (jmp_ext),
    .sp_q   (stack_ptr),
    .sreg_q (status),
    .rd_val (core_rdata)
  );

  assign page_d = page_q[0];
  assign page_x = page_q[1];
  assign page_y = page_q[2];
  assign page_z = page_q[3];

  dsd_read_mux u_mux (
    .region     (region),
    .gpr_rdata  (gpr_rdata),
    .io_rdata   (io_rdata),
    .core_rdata (core_rdata),
    .mem_rdata  (mem_rdata),
    .rdata      (acc_rdata)
  );

  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd && acc_wr) |->
      $onehot0({gpr_re, gpr_we, io_re, io_we, mem_re, mem_we, core_we}));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd || acc_wr) |->
      !(gpr_re || gpr_we || io_re || io_we || mem_re || mem_we));

  // R11
  core_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_CORE) |-> !(io_re || io_we));

  // R2
  io_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_re || io_we) |->
      (32'(io_port) == 32'(acc_addr) - GPR_N && 32'(acc_addr) < GPR_N + IO_N - 8));

endmodule

// File: tb/test_dspace_decode.sv
module test_dspace_decode;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_rd = 1'b0;
  logic        acc_wr = 1'b0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  acc_rdata;
  logic [4:0]  gpr_idx;
  logic        gpr_re, gpr_we;
  logic [7:0]  gpr_rdata;
  logic [5:0]  io_port;
  logic        io_re, io_we;
  logic [7:0]  io_rdata;
  logic [15:0] mem_addr;
  logic        mem_re, mem_we;
  logic [7:0]  mem_rdata;
  logic [7:0]  out_wdata;
  logic [7:0]  page_d, page_x, page_y, page_z, jmp_ext, status;
  logic [15:0] stack_ptr;

  // narrow-stack instance outputs
  logic [7:0]  n_rdata, n_wd, n_pd, n_px, n_py, n_pz, n_je, n_st;
  logic [4:0]  n_gi;
  logic [5:0]  n_ip;
  logic [15:0] n_ma, n_sp;
  logic        n_gr, n_gw, n_ir, n_iw, n_mr, n_mw;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign gpr_rdata = 8'hA0 ^ {3'b000, gpr_idx};
  assign io_rdata  = {2'b11, io_port};
  assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

  dspace_decode i_dspace_decode (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_rd(acc_rd),
    .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .gpr_idx(gpr_idx), .gpr_re(gpr_re), .gpr_we(gpr_we), .gpr_rdata(gpr_rdata),
    .io_port(io_port), .io_re(io_re), .io_we(io_we), .io_rdata(io_rdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .out_wdata(out_wdata), .page_d(page_d), .page_x(page_x), .page_y(page_y),
    .page_z(page_z), .jmp_ext(jmp_ext), .stack_ptr(stack_ptr), .status(status)
  );

  dspace_decode #(.SP_WIDE(1'b0)) i_dspace_decode_narrow (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_rd(acc_rd),
    .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(n_rdata),
    .gpr_idx(n_gi), .gpr_re(n_gr), .gpr_we(n_gw), .gpr_rdata(8'h00),
    .io_port(n_ip), .io_re(n_ir), .io_we(n_iw), .io_rdata(8'h00),
    .mem_addr(n_ma), .mem_re(n_mr), .mem_we(n_mw), .mem_rdata(8'h00),
    .out_wdata(n_wd), .page_d(n_pd), .page_x(n_px), .page_y(n_py),
    .page_z(n_pz), .jmp_ext(n_je), .stack_ptr(n_sp), .status(n_st)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_addr = a; acc_rd = 1'b1;
    #1 d = acc_rdata;
    acc_rd = 1'b0;
  endtask

  // {address, kind (0 gpr, 1 io, 2 core, 3 mem), expected index}
  localparam int NV = 10;
  localparam logic [33:0] VEC [NV] = '{
    {16'd0,     2'd0, 16'd0},
    {16'd31,    2'd0, 16'd31},
    {16'd32,    2'd1, 16'd0},
    {16'd55,    2'd1, 16'd23},
    {16'd87,    2'd1, 16'd55},
    {16'd88,    2'd2, 16'd56},
    {16'd95,    2'd2, 16'd63},
    {16'd96,    2'd3, 16'd96},
    {16'd300,   2'd3, 16'd300},
    {16'hFFFF,  2'd3, 16'hFFFF}
  };

  function automatic logic [7:0] exp_rdata(input logic [1:0] k, input logic [15:0] a,
                                           input logic [15:0] s);
    case (k)
      2'd0: return 8'hA0 ^ a[7:0];
      2'd1: return 8'hC0 | s[7:0];
      2'd2: return 8'h00;
      default: return a[7:0] ^ 8'h5A;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check({page_d, page_x, page_y, page_z, jmp_ext, status} == '0 && stack_ptr == 0,
          "R12", {page_x, page_y, page_z, status}, 0);

    // R4 idle: no strobes
    #1 check(!(gpr_re | gpr_we | io_re | io_we | mem_re | mem_we), "R4",
             {gpr_re, gpr_we, io_re, io_we, mem_re, mem_we}, 0);

    // R1 R2 R3 R11 decode table, read direction
    for (int i = 0; i < NV; i++) begin
      logic [15:0] a, s;
      logic [1:0] k;
      logic [5:0] got, exp;
      {a, k, s} = VEC[i];
      @(negedge clk);
      acc_addr = a; acc_rd = 1'b1;
      #1;
      got = {gpr_re, io_re, mem_re, 3'b000};
      exp = {k == 2'd0, k == 2'd1, k == 2'd3, 3'b000};
      check(got == exp, "R1/R2/R3 strobe", {a, 10'd0, got}, {a, 10'd0, exp});
      if (k == 2'd0) check(gpr_idx == s[4:0], "R1", gpr_idx, s);
      if (k == 2'd1) check(io_port == s[5:0], "R2", io_port, s);
      if (k == 2'd2) check(!io_re, "R11", io_re, 0);
      if (k == 2'd3) check(mem_addr == s, "R3", mem_addr, s);
      check(acc_rdata == exp_rdata(k, a, s), "R13 read", acc_rdata, exp_rdata(k, a, s));
      acc_rd = 1'b0;
    end

    // R5 enabled page registers
    wr(16'd89, 8'h12); wr(16'd90, 8'h34); wr(16'd91, 8'h56);
    check({page_x, page_y, page_z} == 24'h123456, "R5",
          {page_x, page_y, page_z}, 24'h123456);
    rd(16'd90, d);
    check(d == 8'h34, "R5", d, 8'h34);

    // R6 disabled page register
    wr(16'd88, 8'h77);
    check(page_d == 8'h00, "R6", page_d, 0);
    rd(16'd88, d);
    check(d == 8'h00, "R6", d, 0);

    // R7 jump extension
    wr(16'd92, 8'hC3);
    rd(16'd92, d);
    check(jmp_ext == 8'hC3 && d == 8'hC3, "R7", {jmp_ext, d}, 16'hC3C3);

    // R8 wide stack pointer, R9 narrow
    wr(16'd94, 8'hAB); wr(16'd93, 8'hCD);
    check(stack_ptr == 16'hABCD, "R8", stack_ptr, 16'hABCD);
    wr(16'd93, 8'h11);
    check(stack_ptr == 16'hAB11, "R8", stack_ptr, 16'hAB11);
    rd(16'd94, d);
    check(d == 8'hAB, "R8", d, 8'hAB);
    check(n_sp == 16'h0011, "R9", n_sp, 16'h0011);
    @(negedge clk);
    acc_addr = 16'd94; acc_rd = 1'b1;
    #1 check(n_rdata == 8'h00, "R9", n_rdata, 0);
    acc_rd = 1'b0;

    // R10 status byte
    wr(16'd95, 8'h81);
    rd(16'd95, d);
    check(status == 8'h81 && d == 8'h81, "R10", {status, d}, 16'h8181);

    // R13 write lands only at the edge
    @(negedge clk);
    acc_addr = 16'd95; acc_wdata = 8'h3C; acc_wr = 1'b1;
    #1 check(status == 8'h81, "R13 before edge", status, 8'h81);
    @(negedge clk);
    acc_wr = 1'b0;
    check(status == 8'h3C, "R13 after edge", status, 8'h3C);

    // R2 forwarded write, R11 core write stays off the bus
    @(negedge clk);
    acc_addr = 16'd40; acc_wdata = 8'h9E; acc_wr = 1'b1;
    #1 check(io_we && io_port == 6'd8 && out_wdata == 8'h9E, "R2",
             {io_we, io_port, out_wdata}, {1'b1, 6'd8, 8'h9E});
    acc_addr = 16'd92;
    #1 check(!io_we && !io_re, "R11", io_we, 0);
    acc_addr = 16'd5;
    #1 check(gpr_we && gpr_idx == 5'd5 && !io_we && !mem_we, "R1",
             {gpr_we, gpr_idx}, {1'b1, 5'd5});
    acc_addr = 16'd200;
    #1 check(mem_we && mem_addr == 16'd200 && !gpr_we, "R3",
             {mem_we, mem_addr}, {1'b1, 16'd200});
    acc_wr = 1'b0;
    @(negedge clk);
    check(jmp_ext == 8'hC3, "R13 no stray core write", jmp_ext, 8'hC3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule